// File: doc/BRIEF.md
# Serial Program ROM with Built-In Address Counter

This block is a read-only store of 128 words, 20 bits each, that sequences itself. An address counter inside the block picks the word to deliver. Each word leaves the block on a single wire, one bit per enabled clock. Once a start strobe has launched the stream, the block fetches word after word with no gap between them. The counter steps through the store and wraps from the top back to zero. A branch is made by presenting a new 7-bit address with a load strobe. The load is held until the word in flight has finished and then redirects the next fetch.

A word-sync output marks the first bit of every word, so that a receiver can frame the stream without counting. A clock-enable input stalls the whole block, which lets the stream run at a bus bit rate slower than the core clock (a bit period of a few microseconds is typical). The word contents are computed from the address when the code is built, so no external table is needed.

Top module: `serial_prog_rom`

## Requirements
- R1: The word stored at address a (7 bits) is formed as follows: bits 6:0 = a, bits 13:7 = bitwise NOT a, bits 19:14 = a[5:0]. That 20-bit value is then XORed with the constant 0x5A3C6.
- R2: After reset, sdata_o and sync_o stay low and the block stays idle until a start strobe is taken. The counter resets to address 0, so a start with no load delivers word 0 first.
- R3: When en_i is high in an idle cycle, start_i launches the stream. Bit 0 of the first word appears in the cycle after that edge. The first word is taken from the counter, unless a load is presented in the same cycle or is pending, in which case the load address is used.
- R4: Words are sent least-significant bit first, one bit per enabled clock. sync_o is high exactly while bit 0 of a word is on sdata_o, so the sync bits of one word form the pattern 0x00001.
- R5: Words follow one another with no gap: bit 0 of the next word appears on the enabled edge after bit 19. Without a load, each word's address is the previous one plus one, and 127 is followed by 0.
- R6: A load_i pulse with load_addr_i in an enabled cycle does not disturb the word in flight. The word after it comes from the load address, and the counter then continues from there. A load in the cycle that shows bit 19 applies to the word that follows at once.
- R7: While en_i is low, sdata_o, sync_o, the counter and the bit position all hold their values, and start_i and load_i are ignored.
- R8: A start_i pulse while a stream is running has no effect on the word sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| en_i | input | 1 | Clock enable; when low, the whole block holds its state |
| start_i | input | 1 | Word-start strobe; launches the stream from idle |
| load_i | input | 1 | Branch strobe; the next fetch uses load_addr_i |
| load_addr_i | input | 7 | Branch target address |
| sdata_o | output | 1 | Serial word data, LSB first |
| sync_o | output | 1 | High on bit 0 of each word |

## Verification
The two functions that can coincide are the automatic boundary fetch of the next sequential word and a branch load. Both fall on the edge that ends bit 19. The bench raises load_i in the very cycle that shows bit 19, and in another run in the middle of a word. It expects the loaded word to follow immediately in both runs, while the word in flight finishes unchanged. A frozen cycle that carries both a load and a start is also checked: neither strobe may leave a trace on the next word.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int unsigned WORD_W = 20;
  localparam int unsigned ADDR_W = 7;
  localparam logic [WORD_W-1:0] MIX_CONST = 20'h5A3C6;
endpackage

// File: rtl/srom_rst_sync.sv
module srom_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/srom_array.sv
module srom_array #(
  parameter int unsigned WORD_W = 20,
  parameter int unsigned ADDR_W = 7,
  parameter logic [WORD_W-1:0] MIX = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Each bit: an address bit, inverted on odd address-width groups, mixed with a constant.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam logic ABIT = (((g >> (b % ADDR_W)) & 1) != 0);
      localparam logic INV  = (((b / ADDR_W) % 2) != 0);
      assign mem[g][b] = ABIT ^ INV ^ MIX[b];
    end
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/srom_addr_ctr.sv
module srom_addr_ctr #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              fetch_i,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    if (load_i)      sel_addr = load_addr_i;
    else if (pend_q) sel_addr = pend_addr_q;
    else             sel_addr = pc_q;
  end

  always_comb begin
    pc_d        = pc_q;
    pend_d      = pend_q;
    pend_addr_d = pend_addr_q;
    if (fetch_i) begin
      pc_d   = sel_addr + 1'b1;
      pend_d = 1'b0;
    end else if (load_i) begin
      pend_d      = 1'b1;
      pend_addr_d = load_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (en_i) begin
      pc_q        <= pc_d;
      pend_q      <= pend_d;
      pend_addr_q <= pend_addr_d;
    end
  end

  assign fetch_addr_o = sel_addr;
endmodule

// File: rtl/srom_shifter.sv
module srom_shifter #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              fetch_o,
  output logic              sdata_o,
  output logic              sync_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  bidx_q, bidx_d;
  logic              run_q, run_d;
  logic              fetch;

  assign fetch = en_i && (run_q ? (bidx_q == LAST_BIT) : start_i);

  always_comb begin
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    run_d   = run_q;
    if (fetch) begin
      shreg_d = word_i;
      bidx_d  = '0;
      run_d   = 1'b1;
    end else if (run_q) begin
      shreg_d = shreg_q >> 1;
      bidx_d  = bidx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      bidx_q  <= '0;
      run_q   <= 1'b0;
    end else if (en_i) begin
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
      run_q   <= run_d;
    end
  end

  assign fetch_o = fetch;
  assign sdata_o = run_q & shreg_q[0];
  assign sync_o  = run_q & (bidx_q == '0);
endmodule

// File: rtl/serial_prog_rom.sv
module serial_prog_rom
  import srom_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_W,
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter logic [WORD_BITS-1:0] CONTENT_MIX = MIX_CONST
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 start_i,
  input  logic                 load_i,
  input  logic [ADDR_BITS-1:0] load_addr_i,
  output logic                 sdata_o,
  output logic                 sync_o
);
  logic                 rst_n_int;
  logic                 fetch;
  logic [ADDR_BITS-1:0] fetch_addr;
  logic [WORD_BITS-1:0] fetch_word;

  srom_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  srom_addr_ctr #(.ADDR_W(ADDR_BITS)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .en_i         (en_i),
    .load_i       (load_i),
    .load_addr_i  (load_addr_i),
    .fetch_i      (fetch),
    .fetch_addr_o (fetch_addr)
  );

  srom_array #(.WORD_W(WORD_BITS), .ADDR_W(ADDR_BITS), .MIX(CONTENT_MIX)) u_array (
    .addr_i (fetch_addr),
    .data_o (fetch_word)
  );

  srom_shifter #(.WORD_W(WORD_BITS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .en_i    (en_i),
    .start_i (start_i),
    .word_i  (fetch_word),
    .fetch_o (fetch),
    .sdata_o (sdata_o),
    .sync_o  (sync_o)
  );
endmodule

// File: rtl/serial_prog_rom_chk.sv
module serial_prog_rom_chk #(
  parameter int unsigned WORD_BITS = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sdata_o,
  input logic sync_o
);
  localparam int unsigned CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic             started_q;
  logic [CNT_W-1:0] cnt_q;

  // Independent bit-position tracker, synchronised on the first sync pulse.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!started_q) begin
      if (sync_o) begin
        started_q <= 1'b1;
        cnt_q     <= en_i ? CNT_W'(1) : '0;
      end
    end else if (en_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R4, R5: sync marks every word start, spaced by exactly one word of enabled clocks
  a_r4_sync_cadence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (sync_o == (cnt_q == '0)));

  // R4: sync lasts one enabled bit only
  a_r4_sync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && en_i) |=> !sync_o);

  // R7: a disabled edge changes no output
  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sdata_o) && $stable(sync_o)));

  // R2: before the first word the data line is quiet
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!started_q && !sync_o) |-> !sdata_o);
endmodule

bind serial_prog_rom serial_prog_rom_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .sdata_o (sdata_o),
  .sync_o  (sync_o)
);

// File: tb/serial_prog_rom_tb.sv
module serial_prog_rom_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       start_i = 1'b0;
  logic       load_i = 1'b0;
  logic [6:0] load_addr_i = '0;
  logic       sdata_o, sync_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  serial_prog_rom u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .start_i(start_i),
    .load_i(load_i), .load_addr_i(load_addr_i), .sdata_o(sdata_o), .sync_o(sync_o)
  );

  // Expected content from R1.
  function automatic logic [19:0] rom_ref(input int a);
    logic [6:0] a7;
    a7 = a[6:0];
    return {a7[5:0], ~a7, a7} ^ 20'h5A3C6;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; en_i = 1'b1; start_i = 1'b0; load_i = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();
  endtask

  task automatic start_at(input logic [6:0] a, input bit use_load);
    load_i = use_load; load_addr_i = a; start_i = 1'b1;
    tick();
    start_i = 1'b0; load_i = 1'b0;
  endtask

  // kind: 0 none, 1 load, 2 freeze with ignored strobes, 3 start pulse
  task automatic read_word(output logic [19:0] w, output logic [19:0] s,
                           input int ev_bit, input int kind, input logic [6:0] ev_addr);
    int unstable = 0;
    for (int b = 0; b < 20; b++) begin
      w[b] = sdata_o;
      s[b] = sync_o;
      if (b == ev_bit) begin
        case (kind)
          1: begin load_i = 1'b1; load_addr_i = ev_addr; end
          2: begin
            en_i = 1'b0; load_i = 1'b1; load_addr_i = ev_addr; start_i = 1'b1;
            for (int f = 0; f < 4; f++) begin
              tick();
              if (sdata_o !== w[b] || sync_o !== s[b]) unstable++;
            end
            en_i = 1'b1; load_i = 1'b0; start_i = 1'b0;
            chk(unstable == 0, "R7 outputs held while disabled", unstable, 0);
          end
          3: start_i = 1'b1;
          default: ;
        endcase
      end
      tick();
      load_i = 1'b0; start_i = 1'b0;
    end
  endtask

  localparam int NV = 6;
  localparam logic [6:0] VA [NV] = '{7'd0, 7'd5, 7'd64, 7'd125, 7'd127, 7'd42};
  localparam int         VN [NV] = '{3, 2, 2, 4, 2, 1};

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] w, s;
    int bad;

    // R2: reset state and idle quiet
    do_reset();
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (sdata_o !== 1'b0 || sync_o !== 1'b0) bad++;
      tick();
    end
    chk(bad == 0, "R2 idle outputs low", bad, 0);

    // R2, R5: start without load begins at address 0
    start_at(7'd0, 1'b0);
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(0), "R2 first word is address 0", w, rom_ref(0));
    chk(s == 20'h00001, "R4 sync pattern", s, 20'h00001);
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(1), "R5 sequential step", w, rom_ref(1));

    // Vector table: R1, R3, R5 over several start addresses, including wrap
    for (int v = 0; v < NV; v++) begin
      do_reset();
      start_at(VA[v], 1'b1);
      for (int k = 0; k < VN[v]; k++) begin
        read_word(w, s, -1, 0, 0);
        chk(w == rom_ref(int'(VA[v]) + k), "R1 R5 word content and order", w, rom_ref(int'(VA[v]) + k));
        chk(s == 20'h00001, "R4 one sync per word", s, 20'h00001);
      end
    end

    // R6: load mid-word
    do_reset();
    start_at(7'd10, 1'b1);
    read_word(w, s, 5, 1, 7'd90);
    chk(w == rom_ref(10), "R6 word in flight intact", w, rom_ref(10));
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(90), "R6 branch target", w, rom_ref(90));
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(91), "R6 continue after branch", w, rom_ref(91));

    // R6: load in the last-bit cycle coincides with the boundary fetch
    do_reset();
    start_at(7'd20, 1'b1);
    read_word(w, s, 19, 1, 7'd3);
    chk(w == rom_ref(20), "R6 last-bit load word intact", w, rom_ref(20));
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(3), "R6 last-bit load applies at once", w, rom_ref(3));

    // R7: freeze mid-word with ignored load and start
    do_reset();
    start_at(7'd30, 1'b1);
    read_word(w, s, 7, 2, 7'd99);
    chk(w == rom_ref(30), "R7 frozen word intact", w, rom_ref(30));
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(31), "R7 load ignored while disabled", w, rom_ref(31));

    // R8: start during stream
    do_reset();
    start_at(7'd40, 1'b1);
    read_word(w, s, 9, 3, 0);
    chk(w == rom_ref(40), "R8 word unaffected", w, rom_ref(40));
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(41), "R8 sequence unaffected", w, rom_ref(41));

    // R3: load while idle is held for the later start
    do_reset();
    load_i = 1'b1; load_addr_i = 7'd77;
    tick();
    load_i = 1'b0;
    repeat (3) tick();
    chk(sdata_o === 1'b0 && sync_o === 1'b0, "R3 idle after lone load", {sdata_o, sync_o}, 0);
    start_at(7'd0, 1'b0);
    read_word(w, s, -1, 0, 0);
    chk(w == rom_ref(77), "R3 pending load used at start", w, rom_ref(77));

    // R2: reset mid-stream returns to quiet idle
    rst_ni = 1'b0;
    tick();
    chk(sdata_o === 1'b0 && sync_o === 1'b0, "R2 reset clears outputs", {sdata_o, sync_o}, 0);
    rst_ni = 1'b1;
    repeat (4) tick();
    chk(sync_o === 1'b0, "R2 stays idle after reset", sync_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule